// File: doc/BRIEF.md
# Thread Interrupt Presenter Register Front End

This block is the register interface of one hardware thread's interrupt presenter. It occupies a 4 KB window and sits on a simple bus. Each request carries a byte offset, a single access-size flag that selects 1 or 4 bytes, a read strobe, a write strobe and write data. Read data and an error flag come back one cycle later. The block holds four things:

- the thread's current priority;
- one pending source with its priority;
- an inter-processor request priority;
- three general-purpose link words.

It drives one interrupt line towards the thread.

An interrupt source controller outside the block offers candidates on a presentation input. The thread's software then works the window. It polls without side effects, accepts the pending interrupt with a 4-byte read, changes its priority with a 1-byte write, and ends an interrupt with a 4-byte write. Offset 0x4 therefore does different things depending on the access size. Priorities count downwards: 0x00 is the most favoured and 0xFF the least. The interrupt word puts the current priority in bits [31:24] and the pending source number in bits [23:0]. Source number 0 means nothing is pending.

A two-state machine tracks whether an interrupt is being presented.

| State | Meaning |
|-------|---------|
| PST_IDLE | No source is pending. |
| PST_PEND | A source is pending and the interrupt line is high. |

| Transition | Cause |
|------------|-------|
| PST_IDLE → PST_PEND | A qualifying presentation, or an end-of-interrupt that raises the inter-processor request. |
| PST_PEND → PST_IDLE | An accept. |

Every other event leaves the state where it is.

Top module: `intp_regif`

## Requirements
- R1: After reset the read data is 0, the error flag is 0 and the interrupt line is 0. The current priority is 0x00, the inter-processor priority is 0xFF, all link words are 0 and no source is pending.
- R2: A 4-byte read at offset 0x0 returns {current priority, pending source} and changes no state.
- R3: A 1-byte read at offset 0x0 or 0x4 returns the current priority in bits [7:0], with zeros above, and changes no state. Only offset bits [11:2] select the register. A 1-byte access is legal only when offset bits [1:0] are 0; its data travels in bits [7:0].
- R4: A 4-byte read at offset 0x4 (accept) returns the word in force before the read. It then copies the pending priority into the current priority, clears the pending source and resets the pending priority to 0xFF. The next accept therefore returns source 0.
- R5: A 1-byte write at offset 0x4 loads the current priority from write data bits [7:0].
- R6: A 4-byte write at offset 0x4 (end-of-interrupt) loads the current priority from write data bits [31:24]. If the inter-processor priority is then numerically lower than the new current priority, source 2 becomes pending at the inter-processor priority.
- R7: Offset 0xC holds the inter-processor priority. It is read and written with 1-byte accesses only.
- R8: Offsets 0x10, 0x14 and 0x18 are three 32-bit link words. They are read and written with 4-byte accesses only and have no other effect.
- R9: Any other access raises the error flag for one cycle and leaves all state unchanged. This covers any other offset, a wrong size, a 1-byte access with nonzero low bits, a write to offset 0x0, and a read and write strobed together. An illegal read returns 0xFFFFFFFF.
- R10: A presentation becomes the pending source when all of these hold:
  - the source number is nonzero;
  - its priority is numerically lower than the current priority;
  - either nothing is pending or its priority is lower than the pending priority.

  A presentation that fails these conditions is dropped. A presentation is also dropped in any cycle that carries an accept, a priority write or an end-of-interrupt.
- R11: The interrupt line is high exactly when a nonzero source is pending. It is updated in the same cycle as the pending register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_off | input | 12 | Byte offset within the window |
| bus_word | input | 1 | 1 = 4-byte access, 0 = 1-byte access |
| bus_wdata | input | 32 | Write data (1-byte data in [7:0]) |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle flag for an illegal access |
| src_valid | input | 1 | Presentation strobe from the source controller |
| src_id | input | 24 | Presented source number |
| src_prio | input | 8 | Presented priority |
| irq_out | output | 1 | Interrupt request to the thread |

## Verification
The assertions take two things for granted: inputs are stable around the rising edge, and reset is applied before the first access. They also assume the presentation port follows the numeric priority convention. Under these assumptions, a decoded accept must clear the pending source. An end-of-interrupt with a lower inter-processor priority must leave source 2 pending. The stimulus drives every input on the falling edge and holds each access for exactly one cycle. It raises the presentation strobe together with a bus access only on purpose, to test that the bus takes precedence.

// File: rtl/intp_pkg.sv
package intp_pkg;
    localparam int WORD_W = 32;
    localparam int PRIO_W = 8;
    localparam int SRC_W  = WORD_W - PRIO_W;
    localparam int OFF_W  = 12;
    localparam int SLOT_W = OFF_W - 2;

    localparam logic [SLOT_W-1:0] SLOT_POLL  = SLOT_W'(0);
    localparam logic [SLOT_W-1:0] SLOT_TAKE  = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] SLOT_IPR   = SLOT_W'(3);
    localparam logic [SLOT_W-1:0] SLOT_LINK0 = SLOT_W'(4);

    localparam logic [SRC_W-1:0] IPI_SOURCE = SRC_W'(2);

    typedef enum logic [3:0] {
        OP_NONE,
        OP_POLL_WORD,
        OP_POLL_BYTE,
        OP_ACCEPT,
        OP_SET_PRIO,
        OP_EOI,
        OP_IPR_RD,
        OP_IPR_WR,
        OP_LINK_RD,
        OP_LINK_WR,
        OP_BAD
    } op_e;

    typedef enum logic {
        PST_IDLE,
        PST_PEND
    } pst_e;
endpackage

// File: rtl/intp_decode.sv
module intp_decode
    import intp_pkg::*;
#(
    parameter int NLINK = 3,
    localparam int IDX_W = (NLINK > 1) ? $clog2(NLINK) : 1
) (
    input  logic             rd,
    input  logic             wr,
    input  logic [OFF_W-1:0] off,
    input  logic             word,
    output op_e              op,
    output logic [IDX_W-1:0] link_idx
);
    logic [SLOT_W-1:0] slot;
    logic              byte0;
    logic [SLOT_W-1:0] link_rel;
    logic              in_links;

    assign slot     = off[OFF_W-1:2];
    assign byte0    = !word && (off[1:0] == 2'b00);
    assign link_rel = slot - SLOT_LINK0;
    assign in_links = (slot >= SLOT_LINK0) && (link_rel < SLOT_W'(NLINK));

    always_comb begin
        op       = OP_NONE;
        link_idx = '0;
        if (rd && wr) begin
            op = OP_BAD;
        end else if (rd || wr) begin
            op = OP_BAD;
            case (slot)
                SLOT_POLL: begin
                    if (rd && word)       op = OP_POLL_WORD;
                    else if (rd && byte0) op = OP_POLL_BYTE;
                end
                SLOT_TAKE: begin
                    if (rd && word)       op = OP_ACCEPT;
                    else if (rd && byte0) op = OP_POLL_BYTE;
                    else if (wr && word)  op = OP_EOI;
                    else if (wr && byte0) op = OP_SET_PRIO;
                end
                SLOT_IPR: begin
                    if (byte0) op = rd ? OP_IPR_RD : OP_IPR_WR;
                end
                default: begin
                    if (in_links && word) begin
                        op       = rd ? OP_LINK_RD : OP_LINK_WR;
                        link_idx = IDX_W'(link_rel);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/intp_core.sv
module intp_core
    import intp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [WORD_W-1:0] wdata,
    input  logic              src_valid,
    input  logic [SRC_W-1:0]  src_id,
    input  logic [PRIO_W-1:0] src_prio,
    output logic [PRIO_W-1:0] cur_prio,
    output logic [PRIO_W-1:0] ipr_prio,
    output logic [SRC_W-1:0]  pend_src,
    output logic              irq
);
    pst_e              state_q, state_d;
    logic [PRIO_W-1:0] cppr_q, cppr_d;
    logic [PRIO_W-1:0] ipr_q, ipr_d;
    logic [PRIO_W-1:0] pprio_q, pprio_d;
    logic [SRC_W-1:0]  psrc_q, psrc_d;
    logic              bus_owns;
    logic              take_src;
    logic              eoi_ipi;

    assign bus_owns = (op == OP_ACCEPT) || (op == OP_SET_PRIO) || (op == OP_EOI);
    assign take_src = !bus_owns && src_valid && (src_id != '0) && (src_prio < cppr_q) &&
                      ((psrc_q == '0) || (src_prio < pprio_q));
    assign eoi_ipi  = (op == OP_EOI) && (ipr_q < wdata[WORD_W-1 -: PRIO_W]);

    // Register next values
    always_comb begin
        cppr_d  = cppr_q;
        ipr_d   = ipr_q;
        pprio_d = pprio_q;
        psrc_d  = psrc_q;
        case (op)
            OP_ACCEPT: begin
                cppr_d  = pprio_q;
                psrc_d  = '0;
                pprio_d = '1;
            end
            OP_SET_PRIO: cppr_d = wdata[PRIO_W-1:0];
            OP_EOI: begin
                cppr_d = wdata[WORD_W-1 -: PRIO_W];
                if (eoi_ipi) begin
                    psrc_d  = IPI_SOURCE;
                    pprio_d = ipr_q;
                end
            end
            OP_IPR_WR: ipr_d = wdata[PRIO_W-1:0];
            default: ;
        endcase
        if (take_src) begin
            psrc_d  = src_id;
            pprio_d = src_prio;
        end
    end

    // Presentation state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PST_IDLE: if (take_src || eoi_ipi) state_d = PST_PEND;
            PST_PEND: if (op == OP_ACCEPT)     state_d = PST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PST_IDLE;
            cppr_q  <= '0;
            ipr_q   <= '1;
            pprio_q <= '1;
            psrc_q  <= '0;
        end else begin
            state_q <= state_d;
            cppr_q  <= cppr_d;
            ipr_q   <= ipr_d;
            pprio_q <= pprio_d;
            psrc_q  <= psrc_d;
        end
    end

    // Outputs
    always_comb begin
        irq      = (state_q == PST_PEND);
        cur_prio = cppr_q;
        ipr_prio = ipr_q;
        pend_src = psrc_q;
    end

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PST_PEND) == (psrc_q != '0)); // R11
    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACCEPT) |=> (psrc_q == '0) && (state_q == PST_IDLE)); // R4
    AST_POLL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POLL_WORD || op == OP_POLL_BYTE) |=> $stable(cppr_q) && $stable(ipr_q)); // R2
    AST_EOI_IPI: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_EOI && ipr_q < wdata[WORD_W-1 -: PRIO_W]) |=> (psrc_q == IPI_SOURCE) && irq); // R6
    AST_BAD_NOSTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BAD) |=> $stable(cppr_q) && $stable(ipr_q)); // R9
endmodule

// File: rtl/intp_links.sv
module intp_links
    import intp_pkg::*;
#(
    parameter int NLINK = 3,
    localparam int IDX_W = (NLINK > 1) ? $clog2(NLINK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] link_q [NLINK];

    for (genvar i = 0; i < NLINK; i++) begin : g_link
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           link_q[i] <= '0;
            else if (wr && idx == IDX_W'(i))      link_q[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NLINK; i++) begin
            if (idx == IDX_W'(i)) rdata = link_q[i];
        end
    end
endmodule

// File: rtl/intp_regif.sv
module intp_regif
    import intp_pkg::*;
#(
    parameter int NLINK = 3,
    localparam int IDX_W = (NLINK > 1) ? $clog2(NLINK) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [11:0] bus_off,
    input  logic        bus_word,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_err,
    input  logic        src_valid,
    input  logic [23:0] src_id,
    input  logic [7:0]  src_prio,
    output logic        irq_out
);
    op_e               op;
    logic [IDX_W-1:0]  link_idx;
    logic [PRIO_W-1:0] cur_prio;
    logic [PRIO_W-1:0] ipr_prio;
    logic [SRC_W-1:0]  pend_src;
    logic [WORD_W-1:0] link_data;
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] rdata_q;
    logic              err_q;

    intp_decode #(.NLINK(NLINK)) u_decode (
        .rd       (bus_rd),
        .wr       (bus_wr),
        .off      (bus_off),
        .word     (bus_word),
        .op       (op),
        .link_idx (link_idx)
    );

    intp_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .wdata     (bus_wdata),
        .src_valid (src_valid),
        .src_id    (src_id),
        .src_prio  (src_prio),
        .cur_prio  (cur_prio),
        .ipr_prio  (ipr_prio),
        .pend_src  (pend_src),
        .irq       (irq_out)
    );

    intp_links #(.NLINK(NLINK)) u_links (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (op == OP_LINK_WR),
        .idx   (link_idx),
        .wdata (bus_wdata),
        .rdata (link_data)
    );

    always_comb begin
        case (op)
            OP_POLL_WORD, OP_ACCEPT: rd_mux = {cur_prio, pend_src};
            OP_POLL_BYTE:            rd_mux = {{(WORD_W-PRIO_W){1'b0}}, cur_prio};
            OP_IPR_RD:               rd_mux = {{(WORD_W-PRIO_W){1'b0}}, ipr_prio};
            OP_LINK_RD:              rd_mux = link_data;
            OP_BAD:                  rd_mux = '1;
            default:                 rd_mux = rdata_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= (op == OP_BAD);
            if (bus_rd) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;

    AST_BAD_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BAD && bus_rd) |=> (bus_rdata == '1) && bus_err); // R9
    AST_LINK_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LINK_RD || op == OP_LINK_WR) |-> (int'(link_idx) < NLINK)); // R8
    AST_WRITE_KEEPS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd) |=> $stable(bus_rdata)); // R9
endmodule

// File: tb/intp_regif_tb.sv
`timescale 1ns/1ps
module intp_regif_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
    logic [11:0] bus_off = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        src_valid = 1'b0;
    logic [23:0] src_id = '0;
    logic [7:0]  src_prio = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // reference model state
    logic [7:0]  m_cppr, m_ipr, m_pprio;
    logic [23:0] m_src;
    logic [31:0] m_link [3];
    logic [31:0] m_rdata;
    logic        m_err;

    always #5 clk = ~clk;

    intp_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_off(bus_off), .bus_word(bus_word), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .src_valid(src_valid),
        .src_id(src_id), .src_prio(src_prio), .irq_out(irq_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cppr = 8'h00; m_ipr = 8'hFF; m_pprio = 8'hFF; m_src = '0;
            for (int i = 0; i < 3; i++) m_link[i] = '0;
            m_rdata = '0; m_err = 1'b0;
        end else begin
            int  slot;
            bit  b0, bad, owns;
            slot = int'(bus_off >> 2);
            b0   = !bus_word && (bus_off[1:0] == 2'b00);
            bad  = 1'b0;
            owns = 1'b0;
            if (bus_rd && bus_wr) bad = 1'b1;
            else if (bus_rd) begin
                if (slot == 0 && bus_word)               m_rdata = {m_cppr, m_src};
                else if ((slot == 0 || slot == 1) && b0) m_rdata = {24'h0, m_cppr};
                else if (slot == 1 && bus_word) begin
                    m_rdata = {m_cppr, m_src};
                    m_cppr = m_pprio; m_src = '0; m_pprio = 8'hFF; owns = 1'b1;
                end
                else if (slot == 3 && b0)                m_rdata = {24'h0, m_ipr};
                else if (slot >= 4 && slot <= 6 && bus_word) m_rdata = m_link[slot-4];
                else bad = 1'b1;
            end else if (bus_wr) begin
                if (slot == 1 && b0) begin m_cppr = bus_wdata[7:0]; owns = 1'b1; end
                else if (slot == 1 && bus_word) begin
                    m_cppr = bus_wdata[31:24]; owns = 1'b1;
                    if (m_ipr < m_cppr) begin m_src = 24'd2; m_pprio = m_ipr; end
                end
                else if (slot == 3 && b0) m_ipr = bus_wdata[7:0];
                else if (slot >= 4 && slot <= 6 && bus_word) m_link[slot-4] = bus_wdata;
                else bad = 1'b1;
            end
            if (bad && bus_rd) m_rdata = 32'hFFFF_FFFF;
            m_err = bad;
            if (!owns && src_valid && src_id != 0 && src_prio < m_cppr &&
                (m_src == 0 || src_prio < m_pprio)) begin
                m_src = src_id; m_pprio = src_prio;
            end
        end
    end

    // per-cycle comparison against the model (R11 for the line)
    always @(negedge clk) begin
        if (rst_n) begin
            chk(bus_rdata === m_rdata, {cur_req, " rdata"}, bus_rdata, m_rdata);
            chk(bus_err === m_err, {cur_req, " err"}, 32'(bus_err), 32'(m_err));
            chk(irq_out === (m_src != 0), "R11 irq", 32'(irq_out), 32'(m_src != 0));
        end
    end

    task automatic acc(input bit r, input bit w, input logic [11:0] o, input bit wd, input logic [31:0] d);
        bus_rd = r; bus_wr = w; bus_off = o; bus_word = wd; bus_wdata = d;
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; src_valid = 0;
    endtask

    task automatic rd_chk(input logic [11:0] o, input bit wd, input logic [31:0] exp, input string req);
        acc(1, 0, o, wd, 0);
        chk(bus_rdata === exp, req, bus_rdata, exp);
    endtask

    task automatic present(input logic [23:0] id, input logic [7:0] pr);
        src_valid = 1; src_id = id; src_prio = pr;
        @(negedge clk);
        src_valid = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=%08h expected=%08h", 32'(checks), 32'(0));
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        chk(bus_rdata === 32'h0 && !bus_err && !irq_out, "R1 reset outputs", {bus_rdata[31:2], bus_err, irq_out}, 32'h0);
        rd_chk(12'h00C, 0, 32'h0000_00FF, "R1 ipr reset");
        rd_chk(12'h000, 0, 32'h0000_0000, "R1 prio reset");
        rd_chk(12'h014, 1, 32'h0, "R1 link reset");

        cur_req = "R5";
        acc(0, 1, 12'h004, 0, 32'h0000_00FF);
        cur_req = "R3";
        rd_chk(12'h000, 0, 32'h0000_00FF, "R3 byte poll 0x0");
        rd_chk(12'h004, 0, 32'h0000_00FF, "R3 byte poll 0x4");

        cur_req = "R10";
        present(24'h000123, 8'h05);
        chk(irq_out === 1'b1, "R10 irq after presentation", 32'(irq_out), 32'h1);
        cur_req = "R2";
        rd_chk(12'h000, 1, 32'hFF00_0123, "R2 poll word");
        rd_chk(12'h000, 1, 32'hFF00_0123, "R2 poll leaves state");
        chk(irq_out === 1'b1, "R2 irq kept after poll", 32'(irq_out), 32'h1);

        cur_req = "R10";
        present(24'h000055, 8'h07);
        rd_chk(12'h000, 1, 32'hFF00_0123, "R10 weaker presentation dropped");
        present(24'h000077, 8'h03);
        rd_chk(12'h000, 1, 32'hFF00_0077, "R10 stronger presentation replaces");

        cur_req = "R4";
        rd_chk(12'h004, 1, 32'hFF00_0077, "R4 accept returns old word");
        chk(irq_out === 1'b0, "R4 irq drops", 32'(irq_out), 32'h0);
        rd_chk(12'h004, 1, 32'h0300_0000, "R4 second accept source 0");
        rd_chk(12'h000, 1, 32'hFF00_0000, "R4 prio after empty accept");

        cur_req = "R10";
        acc(0, 1, 12'h004, 0, 32'h0000_0010);
        present(24'h000044, 8'h10);
        chk(irq_out === 1'b0, "R10 equal priority dropped", 32'(irq_out), 32'h0);
        present(24'h000000, 8'h01);
        chk(irq_out === 1'b0, "R10 source 0 dropped", 32'(irq_out), 32'h0);

        cur_req = "R7";
        acc(0, 1, 12'h00C, 0, 32'h0000_0004);
        rd_chk(12'h00C, 0, 32'h0000_0004, "R7 ipr readback");

        cur_req = "R6";
        acc(0, 1, 12'h004, 1, 32'h0800_0000);
        chk(irq_out === 1'b1, "R6 ipi raised", 32'(irq_out), 32'h1);
        rd_chk(12'h000, 1, 32'h0800_0002, "R6 eoi word");
        acc(0, 1, 12'h004, 1, 32'h0200_0000);
        rd_chk(12'h000, 1, 32'h0200_0002, "R6 eoi no new ipi");
        rd_chk(12'h004, 1, 32'h0200_0002, "R6 accept ipi");
        rd_chk(12'h000, 0, 32'h0000_0004, "R6 prio from ipi");

        cur_req = "R8";
        acc(0, 1, 12'h010, 1, 32'hA1B2_C3D4);
        acc(0, 1, 12'h014, 1, 32'h1234_5678);
        acc(0, 1, 12'h018, 1, 32'hDEAD_0001);
        rd_chk(12'h010, 1, 32'hA1B2_C3D4, "R8 link0");
        rd_chk(12'h014, 1, 32'h1234_5678, "R8 link1");
        rd_chk(12'h018, 1, 32'hDEAD_0001, "R8 link2");
        rd_chk(12'h000, 0, 32'h0000_0004, "R8 no side effect");

        cur_req = "R9";
        rd_chk(12'h001, 0, 32'hFFFF_FFFF, "R9 unaligned byte read");
        chk(bus_err === 1'b1, "R9 err flag", 32'(bus_err), 32'h1);
        rd_chk(12'h00C, 1, 32'hFFFF_FFFF, "R9 word at ipr");
        rd_chk(12'h020, 1, 32'hFFFF_FFFF, "R9 unmapped offset");
        acc(0, 1, 12'h014, 0, 32'h0000_0099);
        chk(bus_err === 1'b1, "R9 byte write link err", 32'(bus_err), 32'h1);
        rd_chk(12'h014, 1, 32'h1234_5678, "R9 link unchanged");
        acc(0, 1, 12'h000, 1, 32'h1100_0000);
        acc(0, 1, 12'h006, 0, 32'h0000_0011);
        acc(1, 1, 12'h004, 0, 32'h0000_0022);
        chk(bus_err === 1'b1 && bus_rdata === 32'hFFFF_FFFF, "R9 rd and wr", bus_rdata, 32'hFFFF_FFFF);
        rd_chk(12'h000, 0, 32'h0000_0004, "R9 prio unchanged");

        cur_req = "R10";
        src_valid = 1; src_id = 24'h9; src_prio = 8'h01;
        acc(0, 1, 12'h004, 0, 32'h0000_00FF);
        chk(irq_out === 1'b0, "R10 bus write wins", 32'(irq_out), 32'h0);
        rd_chk(12'h000, 1, 32'hFF00_0000, "R10 presentation dropped");

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule